// File: doc/BRIEF.md
# Rank Interleave Address Decoder

This block turns a channel address into the physical rank that holds it and the address inside that rank. The channel address space is cut into an ordered list of range rules. Each rule carries four way entries, and each way names a rank and a signed displacement counted in virtual-rank units. The rule that owns the address picks a way from two address bits. The rule's interleave factor (1, 2 or 4) is derived from how many of its ways repeat the rank of way 0. It then shifts the displaced address down by that factor to give the rank-local address. The bits below the way-select field are carried through untouched. The position of the way-select field follows a page-policy input: low bits for a closed-page policy, higher bits for an open-page policy.

Software loads the rule limits and way entries through a small write-only register port. Lookups are presented with a valid strobe and the answer appears, registered, on the next clock. An address that no rule claims comes back as a miss, with every result field set to all ones.

Top module: `rid_rank_decoder`

## Requirements
- R1: After reset `out_valid` and `out_hit` are low and every rule limit is zero, so any lookup made before configuration is a miss.
- R2: A lookup presented with `in_valid` high on a rising edge produces its result on the outputs after that edge, with `out_valid` high for exactly one cycle; without `in_valid`, `out_valid` stays low.
- R3: Rule r covers addresses from the limit of rule r-1 (zero for rule 0) up to but not including its own limit; rules are tried from index 0 upward and the lowest-numbered rule that covers the address wins; a rule whose limit does not exceed its base never matches.
- R4: With `in_closed_page` high the way is channel-address bits [7:6] and rank-address bits [5:0] equal channel-address bits [5:0].
- R5: With `in_closed_page` low the way is channel-address bits [13:12] and rank-address bits [11:0] equal channel-address bits [11:0].
- R6: A rule's interleave factor is 1 when ways 1, 2 and 3 all hold the same rank as way 0, 2 when at least one but not all of them do, and 4 when none do (ways 1 to 3 agreeing among themselves does not count).
- R7: On a hit the rank address is ((caddr + offset * 2^VRANK_SHIFT) mod 2^CADDR_W) divided by the interleave factor, with the pass-through field of R4/R5 replaced by the channel address's own bits; the offset is two's complement.
- R8: `out_rank` is the selected way's rank and `out_dimm` is that rank shifted right by two.
- R9: On a miss `out_hit` is low and `out_rank`, `out_dimm` and `out_raddr` are all ones.
- R10: A write with `cfg_we` high uses `cfg_addr` = {rule index, 3-bit sub-address}: sub-address 0 to 3 loads that way with rank in `cfg_wdata[RANK_W-1:0]` and offset in `cfg_wdata[RANK_W+OFS_W-1:RANK_W]`; sub-address 4 loads the rule limit from the whole of `cfg_wdata`; sub-addresses 5 to 7 and rule indices at or above NUM_RULES change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NUM_RULES)+3 | Rule index and sub-address of the write |
| cfg_wdata | input | CADDR_W | Configuration write data |
| in_valid | input | 1 | Lookup strobe |
| in_caddr | input | CADDR_W | Channel address to decode |
| in_closed_page | input | 1 | 1 selects closed-page way bits, 0 open-page |
| out_valid | output | 1 | Result valid, one cycle after the lookup |
| out_hit | output | 1 | A rule claimed the address |
| out_rank | output | RANK_W | Selected rank, all ones on a miss |
| out_dimm | output | RANK_W-2 | DIMM index, all ones on a miss |
| out_raddr | output | CADDR_W | Rank-local address, all ones on a miss |

## Verification
Every result field comes from a single register stage, so all of them are due on the clock edge after the one that samples `in_valid`. Configuration writes take effect on their own edge and are visible to a lookup in the next cycle. The bench drives each lookup just after a falling edge and compares all four result fields at the next falling edge, half a period after the capturing edge. It also checks that `out_valid` has dropped one cycle later. Sweeps cover every rule shape under both page policies, including out-of-order limits and ignored writes.

// File: rtl/rid_pkg.sv
package rid_pkg;

   // Sub-address of the rule limit inside a rule's register group
   localparam logic [2:0] RID_SUB_LIMIT = 3'd4;

   // Ways per rule; the way select is two address bits wide
   localparam int RID_NWAY = 4;

   typedef enum logic {
      RID_PAGE_OPEN   = 1'b0,
      RID_PAGE_CLOSED = 1'b1
   } rid_page_e;

   // Right-shift amount for the interleave factor, from way-0 matches
   function automatic logic [1:0] rid_ilv_shift(input logic m1,
                                                input logic m2,
                                                input logic m3);
      if (m1 && m2 && m3)     return 2'd0;
      else if (m1 || m2 || m3) return 2'd1;
      else                     return 2'd2;
   endfunction

endpackage

// File: rtl/rid_cfg_regs.sv
module rid_cfg_regs #(
   parameter int CADDR_W   = 37,
   parameter int NUM_RULES = 8,
   parameter int RANK_W    = 4,
   parameter int OFS_W     = 10,
   parameter int RIW       = 3
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         cfg_we,
   input  logic [RIW+2:0]                               cfg_addr,
   input  logic [CADDR_W-1:0]                           cfg_wdata,
   output logic [NUM_RULES-1:0][CADDR_W-1:0]            lim_o,
   output logic [NUM_RULES-1:0][rid_pkg::RID_NWAY-1:0][RANK_W-1:0] rank_o,
   output logic [NUM_RULES-1:0][rid_pkg::RID_NWAY-1:0][OFS_W-1:0]  ofs_o,
   output logic [NUM_RULES-1:0][1:0]                    ilv_sh_o
);
   import rid_pkg::*;

   localparam int NWAY = RID_NWAY;

   logic [RIW-1:0] wr_rule;
   logic [2:0]     wr_sub;

   assign wr_rule = cfg_addr[RIW+2:3];
   assign wr_sub  = cfg_addr[2:0];

   initial begin
      assert (RANK_W + OFS_W <= CADDR_W)
         else $error("rid_cfg_regs: way entry does not fit the write data");
      assert (NUM_RULES <= (1 << RIW))
         else $error("rid_cfg_regs: rule index too narrow");
   end

   for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
      logic                               sel_r;
      logic [CADDR_W-1:0]                 lim_q;
      logic [NWAY-1:0][RANK_W-1:0]        rk_q;
      logic [NWAY-1:0][OFS_W-1:0]         of_q;
      logic [NWAY-1:1]                    same0;

      assign sel_r = cfg_we && (wr_rule == RIW'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lim_q <= '0;
            rk_q  <= '0;
            of_q  <= '0;
         end else if (sel_r) begin
            if (wr_sub == RID_SUB_LIMIT) begin
               lim_q <= cfg_wdata;
            end
            for (int w = 0; w < NWAY; w++) begin
               if (wr_sub == 3'(w)) begin
                  rk_q[w] <= cfg_wdata[RANK_W-1:0];
                  of_q[w] <= cfg_wdata[RANK_W +: OFS_W];
               end
            end
         end
      end

      // Interleave factor is kept per rule so the lookup path only muxes it
      for (genvar w = 1; w < NWAY; w++) begin : g_same
         assign same0[w] = (rk_q[w] == rk_q[0]);
      end

      assign ilv_sh_o[r] = rid_ilv_shift(same0[1], same0[2], same0[3]);
      assign lim_o[r]    = lim_q;
      assign rank_o[r]   = rk_q;
      assign ofs_o[r]    = of_q;
   end

   AST_CFG_LIMIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && wr_sub == RID_SUB_LIMIT && int'(wr_rule) < NUM_RULES)
      |=> lim_o[$past(wr_rule)] == $past(cfg_wdata)); // R10

   AST_CFG_SUB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && wr_sub > RID_SUB_LIMIT)
      |=> ($stable(lim_o) && $stable(rank_o) && $stable(ofs_o))); // R10

   AST_CFG_RULE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(wr_rule) >= NUM_RULES)
      |=> ($stable(lim_o) && $stable(rank_o) && $stable(ofs_o))); // R10

endmodule

// File: rtl/rid_rule_match.sv
module rid_rule_match #(
   parameter int CADDR_W   = 37,
   parameter int NUM_RULES = 8,
   parameter int RIW       = 3
) (
   input  logic [CADDR_W-1:0]                caddr,
   input  logic [NUM_RULES-1:0][CADDR_W-1:0] lim,
   output logic                              hit,
   output logic [RIW-1:0]                    sel
);
   logic [NUM_RULES-1:0] in_rng;

   for (genvar r = 0; r < NUM_RULES; r++) begin : g_rng
      logic [CADDR_W-1:0] base;
      if (r == 0) begin : g_first
         assign base = '0;
      end else begin : g_next
         assign base = lim[r-1];
      end
      assign in_rng[r] = (caddr >= base) && (caddr < lim[r]);
   end

   // Lowest-numbered covering rule wins
   always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int r = NUM_RULES - 1; r >= 0; r--) begin
         if (in_rng[r]) begin
            hit = 1'b1;
            sel = RIW'(r);
         end
      end
   end

endmodule

// File: rtl/rid_way_calc.sv
module rid_way_calc #(
   parameter int CADDR_W     = 37,
   parameter int RANK_W      = 4,
   parameter int OFS_W       = 10,
   parameter int VRANK_SHIFT = 29,
   parameter int CLOSED_LSB  = 6,
   parameter int OPEN_LSB    = 12
) (
   input  logic [CADDR_W-1:0]                          caddr,
   input  logic                                        closed_page,
   input  logic [rid_pkg::RID_NWAY-1:0][RANK_W-1:0]    ranks,
   input  logic [rid_pkg::RID_NWAY-1:0][OFS_W-1:0]     ofs,
   input  logic [1:0]                                  ilv_sh,
   output logic [RANK_W-1:0]                           rank,
   output logic [CADDR_W-1:0]                          raddr
);
   localparam logic [CADDR_W-1:0] CL_MASK = (CADDR_W'(1) << CLOSED_LSB) - CADDR_W'(1);
   localparam logic [CADDR_W-1:0] OP_MASK = (CADDR_W'(1) << OPEN_LSB) - CADDR_W'(1);

   initial begin
      assert (OPEN_LSB + 2 <= CADDR_W && CLOSED_LSB + 2 <= CADDR_W)
         else $error("rid_way_calc: way field outside the address");
      assert (OFS_W < CADDR_W)
         else $error("rid_way_calc: offset wider than the address");
   end

   logic [1:0]         way;
   logic [OFS_W-1:0]   ofs_sel;
   logic [CADDR_W-1:0] vofs;
   logic [CADDR_W-1:0] sum;
   logic [CADDR_W-1:0] scaled;
   logic [CADDR_W-1:0] low_mask;

   assign way     = closed_page ? caddr[CLOSED_LSB +: 2] : caddr[OPEN_LSB +: 2];
   assign rank    = ranks[way];
   assign ofs_sel = ofs[way];

   // Offset times virtual-rank size is a left shift of the sign-extended offset
   if (VRANK_SHIFT >= CADDR_W) begin : g_vofs_gone
      logic unused_ofs;
      assign unused_ofs = ^ofs_sel;
      assign vofs = '0;
   end else begin : g_vofs_shift
      logic [CADDR_W-1:0] ofs_ext;
      assign ofs_ext = {{(CADDR_W-OFS_W){ofs_sel[OFS_W-1]}}, ofs_sel};
      assign vofs    = ofs_ext << VRANK_SHIFT;
   end

   assign sum      = caddr + vofs;
   assign scaled   = sum >> ilv_sh;
   assign low_mask = closed_page ? CL_MASK : OP_MASK;
   assign raddr    = (scaled & ~low_mask) | (caddr & low_mask);

endmodule

// File: rtl/rid_rank_decoder.sv
module rid_rank_decoder #(
   parameter int CADDR_W     = 37,
   parameter int NUM_RULES   = 8,
   parameter int RANK_W      = 4,
   parameter int OFS_W       = 10,
   parameter int VRANK_SHIFT = 29,
   parameter int CLOSED_LSB  = 6,
   parameter int OPEN_LSB    = 12
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_we,
   input  logic [$clog2(NUM_RULES)+2:0]       cfg_addr,
   input  logic [CADDR_W-1:0]                 cfg_wdata,
   input  logic                               in_valid,
   input  logic [CADDR_W-1:0]                 in_caddr,
   input  logic                               in_closed_page,
   output logic                               out_valid,
   output logic                               out_hit,
   output logic [RANK_W-1:0]                  out_rank,
   output logic [RANK_W-3:0]                  out_dimm,
   output logic [CADDR_W-1:0]                 out_raddr
);
   import rid_pkg::*;

   localparam int RIW    = $clog2(NUM_RULES);
   localparam int DIMM_W = RANK_W - 2;
   localparam int NWAY   = RID_NWAY;

   initial begin
      assert (NUM_RULES >= 2) else $error("rid_rank_decoder: need two or more rules");
      assert (RANK_W >= 3)    else $error("rid_rank_decoder: rank too narrow for a DIMM index");
      assert (CLOSED_LSB < OPEN_LSB)
         else $error("rid_rank_decoder: closed-page field must sit below open-page field");
   end

   logic [NUM_RULES-1:0][CADDR_W-1:0]          cfg_lim;
   logic [NUM_RULES-1:0][NWAY-1:0][RANK_W-1:0] cfg_rank;
   logic [NUM_RULES-1:0][NWAY-1:0][OFS_W-1:0]  cfg_ofs;
   logic [NUM_RULES-1:0][1:0]                  cfg_ilv;

   logic               m_hit;
   logic [RIW-1:0]     m_sel;
   logic [RANK_W-1:0]  w_rank;
   logic [CADDR_W-1:0] w_raddr;

   rid_cfg_regs #(
      .CADDR_W  (CADDR_W),
      .NUM_RULES(NUM_RULES),
      .RANK_W   (RANK_W),
      .OFS_W    (OFS_W),
      .RIW      (RIW)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .lim_o    (cfg_lim),
      .rank_o   (cfg_rank),
      .ofs_o    (cfg_ofs),
      .ilv_sh_o (cfg_ilv)
   );

   rid_rule_match #(
      .CADDR_W  (CADDR_W),
      .NUM_RULES(NUM_RULES),
      .RIW      (RIW)
   ) u_match (
      .caddr(in_caddr),
      .lim  (cfg_lim),
      .hit  (m_hit),
      .sel  (m_sel)
   );

   rid_way_calc #(
      .CADDR_W    (CADDR_W),
      .RANK_W     (RANK_W),
      .OFS_W      (OFS_W),
      .VRANK_SHIFT(VRANK_SHIFT),
      .CLOSED_LSB (CLOSED_LSB),
      .OPEN_LSB   (OPEN_LSB)
   ) u_way (
      .caddr      (in_caddr),
      .closed_page(in_closed_page),
      .ranks      (cfg_rank[m_sel]),
      .ofs        (cfg_ofs[m_sel]),
      .ilv_sh     (cfg_ilv[m_sel]),
      .rank       (w_rank),
      .raddr      (w_raddr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hit   <= 1'b0;
         out_rank  <= '1;
         out_dimm  <= '1;
         out_raddr <= '1;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_hit   <= m_hit;
            out_rank  <= m_hit ? w_rank : '1;
            out_dimm  <= m_hit ? w_rank[RANK_W-1:2] : {DIMM_W{1'b1}};
            out_raddr <= m_hit ? w_raddr : '1;
         end
      end
   end

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2

   AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && m_hit) |-> in_caddr < cfg_lim[m_sel]); // R3

   AST_CLOSED_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_closed_page && m_hit)
      |=> out_raddr[CLOSED_LSB-1:0] == $past(in_caddr[CLOSED_LSB-1:0])); // R4

   AST_OPEN_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_closed_page && m_hit)
      |=> out_raddr[OPEN_LSB-1:0] == $past(in_caddr[OPEN_LSB-1:0])); // R5

   AST_DIMM_TRACKS_RANK: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_dimm == out_rank[RANK_W-1:2]); // R8

   AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_hit) |-> (&out_rank && &out_dimm && &out_raddr)); // R9

endmodule

// File: tb/rid_rank_decoder_tb.sv
`timescale 1ns/1ps
module rid_rank_decoder_tb;
   localparam int AW = 16;
   localparam int NR = 3;
   localparam int RW = 4;
   localparam int OW = 6;
   localparam int VS = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [4:0]    cfg_addr = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          in_valid = 1'b0;
   logic [AW-1:0] in_caddr = '0;
   logic          in_closed_page = 1'b0;
   logic          out_valid;
   logic          out_hit;
   logic [RW-1:0] out_rank;
   logic [RW-3:0] out_dimm;
   logic [AW-1:0] out_raddr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int m_lim [NR];
   int m_rank[NR][4];
   int m_ofs [NR][4];

   always #4 clk = ~clk;

   rid_rank_decoder #(
      .CADDR_W(AW), .NUM_RULES(NR), .RANK_W(RW), .OFS_W(OW),
      .VRANK_SHIFT(VS), .CLOSED_LSB(6), .OPEN_LSB(12)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_caddr(in_caddr),
      .in_closed_page(in_closed_page), .out_valid(out_valid), .out_hit(out_hit),
      .out_rank(out_rank), .out_dimm(out_dimm), .out_raddr(out_raddr)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input int rule, input int sub, input int data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = 5'((rule << 3) | sub);
      cfg_wdata = AW'(data);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic set_way(input int rule, input int w, input int rank, input int ofs);
      cfg_write(rule, w, ((ofs & 63) << 4) | rank);
      m_rank[rule][w] = rank;
      m_ofs[rule][w]  = ofs;
   endtask

   task automatic set_lim(input int rule, input int lim);
      cfg_write(rule, 4, lim);
      m_lim[rule] = lim;
   endtask

   // Expected values from the requirements, arithmetic only
   function automatic void model(input int a, input bit cp, output bit h,
                                 output int rk, output int dm, output int ra);
      int base, w, lowb, cnt, f, s, lm;
      base = 0; h = 0; rk = 15; dm = 3; ra = 16'hFFFF;
      for (int r = 0; r < NR; r++) begin
         if (!h && a >= base && a < m_lim[r]) begin
            h    = 1;
            w    = cp ? ((a >> 6) & 3) : ((a >> 12) & 3);
            lowb = cp ? 6 : 12;
            cnt  = 0;
            for (int k = 1; k < 4; k++) if (m_rank[r][k] == m_rank[r][0]) cnt++;
            f    = (cnt == 3) ? 1 : ((cnt > 0) ? 2 : 4);
            s    = (a + m_ofs[r][w] * 256) & 16'hFFFF;
            lm   = (1 << lowb) - 1;
            ra   = (((s / f) & ~lm) | (a & lm)) & 16'hFFFF;
            rk   = m_rank[r][w];
            dm   = rk >> 2;
         end
         base = m_lim[r];
      end
   endfunction

   task automatic lookup(input int a, input bit cp, input string tag);
      bit h; int rk, dm, ra;
      model(a, cp, h, rk, dm, ra);
      @(negedge clk);
      in_valid = 1'b1; in_caddr = AW'(a); in_closed_page = cp;
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R2 valid"}, int'(out_valid), 1);
      check({tag, h ? " hit" : " R9 hit"}, int'(out_hit), int'(h));
      check({tag, " R8 rank"}, int'(out_rank), rk);
      check({tag, " R8 dimm"}, int'(out_dimm), dm);
      check({tag, " R7 raddr"}, int'(out_raddr), ra);
   endtask

   task automatic sweep(input string tag);
      for (int cp = 0; cp < 2; cp++) begin
         for (int a = 0; a < 65536; a += 37) begin
            lookup(a, cp[0], {tag, cp ? " R4" : " R5", " R3 R6"});
         end
         lookup(65535, cp[0], {tag, " R9 top"});
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expected=finish actual=hang");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < NR; r++) begin
         m_lim[r] = 0;
         for (int w = 0; w < 4; w++) begin m_rank[r][w] = 0; m_ofs[r][w] = 0; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state and unconfigured miss
      check("R1 out_valid", int'(out_valid), 0);
      check("R1 out_hit", int'(out_hit), 0);
      lookup(16'h1234, 1'b1, "R1 unconfigured R9");
      // R2: strobe lasts one cycle
      @(negedge clk);
      check("R2 valid drops", int'(out_valid), 0);

      // Config 1: factor 1, 2 and 4 rules (R6), negative offsets (R7), R10 loads
      set_lim(0, 16'h4000); set_lim(1, 16'hA000); set_lim(2, 16'hFF00);
      set_way(0, 0, 3, 0);  set_way(0, 1, 3, 1);  set_way(0, 2, 3, 2);  set_way(0, 3, 3, -1);
      set_way(1, 0, 13, -3); set_way(1, 1, 9, 4); set_way(1, 2, 13, 7); set_way(1, 3, 2, -32);
      set_way(2, 0, 1, 31); set_way(2, 1, 4, -8); set_way(2, 2, 4, 0);  set_way(2, 3, 7, 12);
      sweep("C1 R10");

      // Config 2: out-of-order limits, empty rule 1, overlap resolved by order (R3)
      set_lim(0, 16'h8000); set_lim(1, 16'h6000); set_lim(2, 16'hC000);
      set_way(0, 0, 0, 5);  set_way(0, 1, 8, -5); set_way(0, 2, 0, 9);  set_way(0, 3, 8, 0);
      set_way(1, 0, 14, 0); set_way(1, 1, 14, 0); set_way(1, 2, 14, 0); set_way(1, 3, 14, 0);
      sweep("C2 R3");

      // Config 3: back to config 1, then writes that R10 says are ignored
      set_lim(0, 16'h4000); set_lim(1, 16'hA000); set_lim(2, 16'hFF00);
      set_way(0, 0, 3, 0);  set_way(0, 1, 3, 1);  set_way(0, 2, 3, 2);  set_way(0, 3, 3, -1);
      set_way(1, 0, 13, -3); set_way(1, 1, 9, 4); set_way(1, 2, 13, 7); set_way(1, 3, 2, -32);
      cfg_write(0, 5, 16'hFFFF); cfg_write(1, 6, 16'h0000); cfg_write(2, 7, 16'h1234);
      cfg_write(3, 4, 16'h0000); cfg_write(3, 0, 16'hFFFF);
      sweep("C3 R10 ignored");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule